// File: doc/BRIEF.md
# Credit-Paced Receive Word Output

This block sits between a receive word buffer and a user sink. Frame words arrive on a write port together with their frame markers and sideband. They are held in a small first-in first-out store and then presented to the sink one word per cycle. Pacing comes from a credit counter rather than from a per-cycle handshake. Software arms the counter by pulsing a load strobe with an initial credit value. Every cycle in which a word is presented spends one credit, and presentation stops when no credit is left. Every cycle in which the sink raises its acknowledge input gives one credit back.

Each presented word carries a valid flag and start-of-frame and end-of-frame flags. The closing word of a frame also carries a 6-bit count of valid bytes and a 24-bit status word. The opening word may carry a 56-bit preamble with its own qualifier. An almost-full flag reports buffer occupancy, so a sink that holds acknowledge low can see the buffer filling before it overflows. A sink that keeps acknowledge high at all times receives words on consecutive cycles.

Top module: `rxo_credit_out`

## Requirements
- R1: A cycle with `cred_load` high replaces the credit count with `cred_init`, whatever the count was before and whatever else happens in that cycle.
- R2: Every cycle with `out_vld` high spends one credit. With `snk_ack` held low, the number of words presented after a load equals the loaded credit.
- R3: While the credit count is zero, `out_vld` stays low and buffered words are kept. They come out later in write order, once credit arrives.
- R4: Every cycle with `snk_ack` high returns one credit. A single acknowledge pulse at zero credit releases exactly one more word.
- R5: In a cycle that both presents a word and sees `snk_ack`, the credit count does not change. With one credit and `snk_ack` held high, words stream on consecutive cycles in write order.
- R6: The credit count saturates at 2**CW-1 when acknowledges arrive with nothing to send, and it never wraps below zero.
- R7: `out_first` and `out_last` repeat the markers written with the word, and both are low whenever `out_vld` is low.
- R8: `out_mod` and `out_stat` carry the written values only on a presented word with `out_last` high, and are zero on every other cycle.
- R9: `out_pre` and `out_pre_vld` carry the written values only on a presented word with `out_first` high, and are zero on every other cycle.
- R10: `buf_afull` is high exactly while buffer occupancy is at least `AF_LEVEL` words.
- R11: A word written into an empty buffer when credit is available appears on `out_vld` in the cycle after the write.
- R12: After reset the credit count is zero, the buffer is empty and `out_vld`, `buf_afull` and all sideband outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one word into the buffer |
| wr_data | input | DW | Word payload |
| wr_first | input | 1 | Word opens a frame |
| wr_last | input | 1 | Word closes a frame |
| wr_mod | input | 6 | Valid byte count of a closing word |
| wr_stat | input | 24 | Status of a closing word |
| wr_pre | input | 56 | Preamble of an opening word |
| wr_pre_vld | input | 1 | Preamble present on an opening word |
| cred_load | input | 1 | Load strobe for the credit count |
| cred_init | input | CW | Initial credit value |
| snk_ack | input | 1 | Sink consumed a word, returns one credit |
| out_vld | output | 1 | Presented word is valid |
| out_data | output | DW | Presented payload |
| out_first | output | 1 | Start-of-frame flag |
| out_last | output | 1 | End-of-frame flag |
| out_mod | output | 6 | Byte count, closing word only |
| out_stat | output | 24 | Status, closing word only |
| out_pre | output | 56 | Preamble, opening word only |
| out_pre_vld | output | 1 | Preamble qualifier, opening word only |
| buf_afull | output | 1 | Occupancy at or above AF_LEVEL |

## Verification
The credit-arithmetic properties assume that `cred_load` is low during reset and that the writer never writes into a full buffer. Under that assumption, every change of the count can be traced to a load, a presented word or an acknowledge. The directed stimulus keeps each test below the buffer depth and drives the load strobe only after reset is released. The sideband properties assume nothing about the inputs. The stimulus deliberately writes nonzero byte counts, status and preamble on words that do not qualify for them, so the masking is actually exercised.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  localparam int MOD_W  = 6;
  localparam int STAT_W = 24;
  localparam int PRE_W  = 56;

  typedef struct packed {
    logic              first;
    logic              last;
    logic [MOD_W-1:0]  mod;
    logic [STAT_W-1:0] stat;
    logic              pre_vld;
    logic [PRE_W-1:0]  pre;
  } rxo_meta_t;

  localparam int META_W = $bits(rxo_meta_t);
endpackage

// File: rtl/rxo_buf.sv
module rxo_buf #(
  parameter int W        = 16,
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  input  logic         rd_en,
  output logic [W-1:0] rd_word,
  output logic         empty,
  output logic         afull
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_C = (AW+1)'(DEPTH);
  localparam logic [AW:0]   AF_C   = (AW+1)'(AF_LEVEL);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          wr_ok, rd_ok;

  assign empty = (cnt == '0);
  assign wr_ok = wr_en && (cnt != FULL_C);
  assign rd_ok = rd_en && !empty;
  assign afull = (cnt >= AF_C);

  // storage and registered read port kept free of reset for RAM inference
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_word;
    if (rd_ok) rd_word <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= (wp == LAST_C) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == LAST_C) ? '0 : rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rxo_credit.sv
module rxo_credit #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] init,
  input  logic          spend,
  input  logic          give,
  output logic [CW-1:0] credit,
  output logic          has
);
  localparam logic [CW-1:0] MAX_C = '1;

  assign has = (credit != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      credit <= '0;
    end else if (load) begin
      credit <= init;
    end else begin
      case ({spend, give})
        2'b10:   if (has) credit <= credit - 1'b1;
        2'b01:   if (credit != MAX_C) credit <= credit + 1'b1;
        default: credit <= credit;
      endcase
    end
  end
endmodule

// File: rtl/rxo_credit_out.sv
module rxo_credit_out
  import rxo_pkg::*;
#(
  parameter int DW       = 64,
  parameter int DEPTH    = 32,
  parameter int CW       = 8,
  parameter int AF_LEVEL = DEPTH - 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              wr_first,
  input  logic              wr_last,
  input  logic [MOD_W-1:0]  wr_mod,
  input  logic [STAT_W-1:0] wr_stat,
  input  logic [PRE_W-1:0]  wr_pre,
  input  logic              wr_pre_vld,
  input  logic              cred_load,
  input  logic [CW-1:0]     cred_init,
  input  logic              snk_ack,
  output logic              out_vld,
  output logic [DW-1:0]     out_data,
  output logic              out_first,
  output logic              out_last,
  output logic [MOD_W-1:0]  out_mod,
  output logic [STAT_W-1:0] out_stat,
  output logic [PRE_W-1:0]  out_pre,
  output logic              out_pre_vld,
  output logic              buf_afull
);
  localparam int WW = DW + META_W;

  rxo_meta_t     wr_meta, rd_meta;
  logic [WW-1:0] wr_word, rd_word;
  logic          buf_empty, credit_has, send, vld_q;
  logic [CW-1:0] credit_q;

  // sideband is masked on entry so stored words already obey the qualifiers
  always_comb begin
    wr_meta.first   = wr_first;
    wr_meta.last    = wr_last;
    wr_meta.mod     = wr_last ? wr_mod : '0;
    wr_meta.stat    = wr_last ? wr_stat : '0;
    wr_meta.pre_vld = wr_first & wr_pre_vld;
    wr_meta.pre     = (wr_first & wr_pre_vld) ? wr_pre : '0;
  end
  assign wr_word = {wr_data, wr_meta};

  assign send = !buf_empty && credit_has;

  rxo_buf #(.W(WW), .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) buf_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .rd_en   (send),
    .rd_word (rd_word),
    .empty   (buf_empty),
    .afull   (buf_afull)
  );

  rxo_credit #(.CW(CW)) cred_i (
    .clk    (clk),
    .rst    (rst),
    .load   (cred_load),
    .init   (cred_init),
    .spend  (send),
    .give   (snk_ack),
    .credit (credit_q),
    .has    (credit_has)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= send;
  end

  assign rd_meta     = rd_word[META_W-1:0];
  assign out_vld     = vld_q;
  assign out_data    = rd_word[WW-1:META_W];
  assign out_first   = vld_q & rd_meta.first;
  assign out_last    = vld_q & rd_meta.last;
  assign out_mod     = vld_q ? rd_meta.mod : '0;
  assign out_stat    = vld_q ? rd_meta.stat : '0;
  assign out_pre     = vld_q ? rd_meta.pre : '0;
  assign out_pre_vld = vld_q & rd_meta.pre_vld;
endmodule

// File: rtl/rxo_credit_out_chk.sv
module rxo_credit_out_chk
  import rxo_pkg::*;
#(
  parameter int CW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              out_vld,
  input logic              out_first,
  input logic              out_last,
  input logic [MOD_W-1:0]  out_mod,
  input logic [STAT_W-1:0] out_stat,
  input logic [PRE_W-1:0]  out_pre,
  input logic              out_pre_vld,
  input logic              snk_ack,
  input logic              cred_load,
  input logic [CW-1:0]     cred_init,
  input logic [CW-1:0]     credit_q,
  input logic              send
);
  localparam logic [CW-1:0] MAX_C = '1;

  a_r7_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (!out_first && !out_last));

  a_r8_tail_only: assert property (@(posedge clk) disable iff (rst)
    !out_last |-> (out_mod == '0 && out_stat == '0));

  a_r9_pre_with_first: assert property (@(posedge clk) disable iff (rst)
    !out_first |-> (!out_pre_vld && out_pre == '0));

  a_r3_credit_gates: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ($past(credit_q) != '0));

  a_r1_load_sets: assert property (@(posedge clk) disable iff (rst)
    $past(cred_load) |-> (credit_q == $past(cred_init)));

  a_r2_spend_one: assert property (@(posedge clk) disable iff (rst)
    ($past(send) && !$past(snk_ack) && !$past(cred_load))
      |-> (credit_q == CW'($past(credit_q) - 1'b1)));

  a_r5_pair_neutral: assert property (@(posedge clk) disable iff (rst)
    ($past(send) && $past(snk_ack) && !$past(cred_load))
      |-> (credit_q == $past(credit_q)));

  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    ($past(credit_q) == MAX_C && $past(snk_ack) && !$past(send) && !$past(cred_load))
      |-> (credit_q == MAX_C));
endmodule

bind rxo_credit_out rxo_credit_out_chk #(.CW(CW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .out_vld     (out_vld),
  .out_first   (out_first),
  .out_last    (out_last),
  .out_mod     (out_mod),
  .out_stat    (out_stat),
  .out_pre     (out_pre),
  .out_pre_vld (out_pre_vld),
  .snk_ack     (snk_ack),
  .cred_load   (cred_load),
  .cred_init   (cred_init),
  .credit_q    (credit_q),
  .send        (send)
);

// File: tb/rxo_credit_out_tb_top.sv
module rxo_credit_out_tb_top;
  localparam int CLK_P    = 10;
  localparam int DW       = 16;
  localparam int DEPTH    = 16;
  localparam int CW       = 3;
  localparam int AF_LEVEL = 12;
  localparam int CMAX     = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, wr_first = 1'b0, wr_last = 1'b0, wr_pre_vld = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [5:0]    wr_mod = '0;
  logic [23:0]   wr_stat = '0;
  logic [55:0]   wr_pre = '0;
  logic          cred_load = 1'b0, snk_ack = 1'b0;
  logic [CW-1:0] cred_init = '0;
  logic          out_vld, out_first, out_last, out_pre_vld, buf_afull;
  logic [DW-1:0] out_data;
  logic [5:0]    out_mod;
  logic [23:0]   out_stat;
  logic [55:0]   out_pre;

  always #(CLK_P/2) clk = ~clk;

  rxo_credit_out #(.DW(DW), .DEPTH(DEPTH), .CW(CW), .AF_LEVEL(AF_LEVEL)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_first(wr_first),
    .wr_last(wr_last), .wr_mod(wr_mod), .wr_stat(wr_stat), .wr_pre(wr_pre),
    .wr_pre_vld(wr_pre_vld), .cred_load(cred_load), .cred_init(cred_init),
    .snk_ack(snk_ack), .out_vld(out_vld), .out_data(out_data), .out_first(out_first),
    .out_last(out_last), .out_mod(out_mod), .out_stat(out_stat), .out_pre(out_pre),
    .out_pre_vld(out_pre_vld), .buf_afull(buf_afull)
  );

  int n_chk = 0, n_bad = 0, tcount = 0, ncap = 0;
  logic [DW-1:0] cap_d [64];
  int            cap_t [64];
  logic          cap_f [64], cap_l [64], cap_pv [64];
  logic [5:0]    cap_m [64];
  logic [23:0]   cap_s [64];
  logic [55:0]   cap_p [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // advance one edge, then sample one time unit later and log presented words
  task automatic tick();
    @(posedge clk); #1;
    tcount++;
    if (out_vld && ncap < 64) begin
      cap_d[ncap] = out_data; cap_t[ncap] = tcount;
      cap_f[ncap] = out_first; cap_l[ncap] = out_last;
      cap_m[ncap] = out_mod; cap_s[ncap] = out_stat;
      cap_p[ncap] = out_pre; cap_pv[ncap] = out_pre_vld;
      ncap++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; cred_load = 1'b0; snk_ack = 1'b0;
    tick(); tick();
    rst = 1'b0;
    ncap = 0;
  endtask

  task automatic load(input int v);
    cred_load = 1'b1; cred_init = CW'(v);
    tick();
    cred_load = 1'b0;
  endtask

  task automatic put(input int d, input bit f, input bit l, input int m,
                     input int s, input longint p, input bit pv);
    wr_en = 1'b1; wr_data = DW'(d); wr_first = f; wr_last = l;
    wr_mod = 6'(m); wr_stat = 24'(s); wr_pre = 56'(p); wr_pre_vld = pv;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk(!out_vld, "R12", "out_vld after reset", out_vld, 0);
    chk(!buf_afull, "R12", "afull after reset", buf_afull, 0);
    chk(out_mod == 0 && out_stat == 0 && out_pre == 0 && !out_pre_vld, "R12",
        "sideband after reset", out_stat, 0);
    chk(!out_first && !out_last, "R7", "flags idle", {out_first, out_last}, 0);
  endtask

  task automatic t_zero_credit();
    do_reset();
    put(16'h0a01, 1, 0, 0, 0, 0, 0);
    put(16'h0a02, 0, 1, 4, 0, 0, 0);
    idle(6);
    chk(ncap == 0, "R3", "words shown with zero credit", ncap, 0);
    load(5);
    idle(3);
    chk(ncap == 2, "R3", "retained words released", ncap, 2);
    chk(cap_d[0] == 16'h0a01 && cap_d[1] == 16'h0a02, "R3", "release order",
        cap_d[1], 16'h0a02);
    chk(cap_t[1] == cap_t[0] + 1, "R1", "loaded credit used at once", cap_t[1], cap_t[0] + 1);
  endtask

  task automatic t_exhaust();
    do_reset();
    load(3);
    for (int i = 0; i < 5; i++) put(16'h0b00 + i, 0, 0, 0, 0, 0, 0);
    idle(6);
    chk(ncap == 3, "R2", "words per loaded credit", ncap, 3);
    chk(cap_d[2] == 16'h0b02, "R2", "third word", cap_d[2], 16'h0b02);
    snk_ack = 1'b1; tick(); snk_ack = 1'b0;
    idle(4);
    chk(ncap == 4, "R4", "one word per ack pulse", ncap, 4);
    chk(cap_d[3] == 16'h0b03, "R4", "released word", cap_d[3], 16'h0b03);
    load(1);
    idle(2);
    chk(ncap == 5, "R1", "reload releases last word", ncap, 5);
  endtask

  task automatic t_stream();
    int t0;
    do_reset();
    load(1);
    t0 = tcount;
    put(16'h0c00, 0, 0, 0, 0, 0, 0);
    snk_ack = 1'b1;
    for (int i = 1; i < 6; i++) put(16'h0c00 + i, 0, 0, 0, 0, 0, 0);
    tick();
    snk_ack = 1'b0;
    chk(ncap == 6, "R5", "streamed words", ncap, 6);
    chk(cap_t[0] == t0 + 2, "R11", "latency after write", cap_t[0], t0 + 2);
    for (int i = 1; i < 6; i++)
      chk(cap_t[i] == cap_t[i-1] + 1 && cap_d[i] == DW'(16'h0c00 + i), "R5",
          "back to back word", cap_d[i], 16'h0c00 + i);
    for (int i = 0; i < 3; i++) put(16'h0c10 + i, 0, 0, 0, 0, 0, 0);
    idle(4);
    chk(ncap == 7, "R5", "credit kept by paired spend and return", ncap, 7);
  endtask

  task automatic t_saturate();
    do_reset();
    snk_ack = 1'b1; idle(CMAX + 6); snk_ack = 1'b0;
    for (int i = 0; i < 10; i++) put(16'h0d00 + i, 0, 0, 0, 0, 0, 0);
    idle(8);
    chk(ncap == CMAX, "R6", "words after saturated credit", ncap, CMAX);
  endtask

  task automatic t_frame();
    do_reset();
    load(7);
    put(16'h0e00, 1, 0, 9, 24'h111111, 56'h00AABBCCDDEEFF, 1);
    put(16'h0e01, 0, 0, 7, 24'h222222, 56'h123, 1);
    put(16'h0e02, 0, 1, 3, 24'h5A5A5A, 56'h456, 1);
    put(16'h0e03, 1, 1, 17, 24'h0F0F0F, 56'h77, 0);
    idle(3);
    chk(ncap == 4, "R7", "frame words", ncap, 4);
    chk(cap_f[0] && !cap_l[0] && !cap_f[1] && !cap_l[1] && cap_l[2] && cap_f[3] && cap_l[3],
        "R7", "start and end flags", {cap_f[0], cap_l[2], cap_f[3], cap_l[3]}, 4'hf);
    chk(cap_m[0] == 0 && cap_s[0] == 0 && cap_m[1] == 0 && cap_s[1] == 0, "R8",
        "mod and status masked off tail", cap_s[1], 0);
    chk(cap_m[2] == 3 && cap_s[2] == 24'h5A5A5A, "R8", "tail status", cap_s[2], 24'h5A5A5A);
    chk(cap_m[3] == 17 && cap_s[3] == 24'h0F0F0F, "R8", "single word frame", cap_m[3], 17);
    chk(cap_pv[0] && cap_p[0] == 56'h00AABBCCDDEEFF, "R9", "preamble on first", cap_p[0],
        56'h00AABBCCDDEEFF);
    chk(!cap_pv[1] && cap_p[1] == 0 && !cap_pv[2] && cap_p[2] == 0, "R9",
        "preamble masked off first", cap_p[1], 0);
    chk(!cap_pv[3] && cap_p[3] == 0, "R9", "preamble without qualifier", cap_p[3], 0);
  endtask

  task automatic t_afull();
    do_reset();
    for (int i = 0; i < AF_LEVEL - 1; i++) put(i, 0, 0, 0, 0, 0, 0);
    chk(!buf_afull, "R10", "afull below level", buf_afull, 0);
    put(16'h0f0f, 0, 0, 0, 0, 0, 0);
    chk(buf_afull, "R10", "afull at level", buf_afull, 1);
    load(1);
    chk(buf_afull, "R10", "afull before drain", buf_afull, 1);
    tick();
    chk(!buf_afull, "R10", "afull after one word leaves", buf_afull, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_credit();
    t_exhaust();
    t_stream();
    t_saturate();
    t_frame();
    t_afull();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule